// File: doc/BRIEF.md
# Nibble-Mapped Reloadable 8-bit Timer

This block is an 8-bit up-counter that advances on single-cycle count pulses. Four pulse sources enter the block; a two-bit field in the control register picks one of them. Software reaches the block through a narrow register port four bits wide. It has three registers: a control register and two data nibbles. Writing a data nibble fills half of an 8-bit preload buffer. Reading a data nibble returns the matching half of the live counter, so the same address returns a value different from the one last written to it.

When the counter steps past 0xFF it produces an overflow. It then restarts either from zero or from the preload buffer, depending on the auto-reload bit in the control register. The rising edge of the overflow pulse sets a sticky interrupt flag. The flag stays set until a dedicated clear input removes it. The pulse sources themselves are generated outside the block.

Top module: `nib_reload_timer`

## Requirements
- R1: After reset the control register, the preload buffer, the counter, the overflow pulse and the interrupt flag are all zero.
- R2: Address 0 is the control register, and a write sets all four bits. Bit 0 enables counting, bits 2:1 select the source and bit 3 enables auto-reload. A read of address 0 returns the stored value. Address 3 reads as zero, and a write to it changes nothing.
- R3: The source index is {bit2, bit1}, giving tick_src[0] through tick_src[3]. The counter advances by one on a clock edge only when the selected source is high. Pulses on unselected sources have no effect.
- R4: While control bit 0 is 0, the counter holds its value whatever the sources do.
- R5: A write to address 1 loads preload bits 3:0, and a write to address 2 loads preload bits 7:4. Neither write alters the counter.
- R6: A read of address 1 returns counter bits 3:0 and a read of address 2 returns counter bits 7:4. Both reads are combinational from the current counter value.
- R7: A count step taken at 0xFF with auto-reload off leaves the counter at 0x00.
- R8: A count step taken at 0xFF with auto-reload on loads the preload buffer value as it stood before that edge.
- R9: ovf_pulse is high for exactly the one cycle after a count step taken at 0xFF.
- R10: The rising edge of the overflow sets irq_flag. The flag stays set until irq_clear is high on a clock edge. If a set and a clear fall on the same edge, the set wins.
- R11: Enabling counting does not copy the preload buffer into the counter. Counting resumes from the counter's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 low nibble, 2 high nibble) |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data, combinational on reg_addr |
| tick_src | input | 4 | Four single-cycle count pulse sources |
| irq_clear | input | 1 | Clears the interrupt flag |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench changes the source select and the enable on the same edge as a tick. The old settings must govern that edge; a design that decodes the new control value too early would count a pulse it should drop. It reads a data nibble just after writing it. A design that routes reads from the preload buffer would return the written value instead of the counter. Both overflow exits are covered: a wrong reload would restart at zero, or at 0x00 plus one. The bench also collides a clear with a new overflow, which a clear-first flag would lose. Re-enabling after a preload write must not jump the counter to the preload value.

// File: rtl/nib_reload_timer.sv
module nib_reload_timer #(
  parameter int CNT_W = 8,
  parameter int NIB_W = 4,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [NIB_W-1:0] reg_wdata,
  output logic [NIB_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]  tick_src,
  input  logic             irq_clear,
  output logic             ovf_pulse,
  output logic             irq_flag
);
  localparam int SEL_W = $clog2(NSRC);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;

  logic [NIB_W-1:0] ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pre_q;
  logic             ovf_q;
  logic             irq_q;

  wire             run_en = ctrl_q[0];
  wire [SEL_W-1:0] src_sel = ctrl_q[SEL_W:1];
  wire             rld_en = ctrl_q[SEL_W+1];
  wire             step   = run_en & tick_src[src_sel];
  wire             wrap   = step & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr && reg_addr == A_LO)   pre_q[NIB_W-1:0] <= reg_wdata;
      if (reg_wr && reg_addr == A_HI)   pre_q[CNT_W-1:NIB_W] <= reg_wdata;
      if (step) cnt_q <= wrap ? (rld_en ? pre_q : '0) : cnt_q + CNT_W'(1);
      ovf_q <= wrap;
      irq_q <= (wrap & ~ovf_q) | (irq_q & ~irq_clear);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_LO:    reg_rdata = cnt_q[NIB_W-1:0];
      A_HI:    reg_rdata = cnt_q[CNT_W-1:NIB_W];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_pulse = ovf_q;
  assign irq_flag  = irq_q;
endmodule

// File: rtl/nib_reload_timer_chk.sv
module nib_reload_timer_chk #(
  parameter int CNT_W = 8,
  parameter int NIB_W = 4,
  parameter int NSRC  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [NIB_W-1:0] reg_wdata,
  input logic [NSRC-1:0]  tick_src,
  input logic             irq_clear,
  input logic [NIB_W-1:0] ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] pre,
  input logic             ovf,
  input logic             irq
);
  wire sel_hi = ctrl[0] && tick_src[ctrl[2:1]];

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> cnt == $past(cnt));
  // R3
  unselected_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !tick_src[ctrl[2:1]]) |=> cnt == $past(cnt));
  // R3
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && cnt != '1) |=> cnt == CNT_W'($past(cnt) + 1));
  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && cnt == '1 && !ctrl[3]) |=> cnt == '0);
  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && cnt == '1 && ctrl[3]) |=> cnt == $past(pre));
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && cnt == '1) |=> ovf);
  // R9
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_hi && cnt == '1) |=> !ovf);
  // R10
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> irq);
  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);
  // R5
  pre_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> pre[NIB_W-1:0] == $past(reg_wdata));
  // R5
  pre_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> pre[CNT_W-1:NIB_W] == $past(reg_wdata));
  // R2
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> ctrl == $past(ctrl));
endmodule

bind nib_reload_timer nib_reload_timer_chk #(.CNT_W(CNT_W), .NIB_W(NIB_W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .tick_src(tick_src), .irq_clear(irq_clear), .ctrl(ctrl_q), .cnt(cnt_q), .pre(pre_q),
  .ovf(ovf_pulse), .irq(irq_flag)
);

// File: tb/nib_reload_timer_tb_top.sv
`timescale 1ns/1ps
module nib_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] reg_rdata;
  logic [3:0] tick_src = 4'd0;
  logic       irq_clear = 1'b0;
  logic       ovf_pulse;
  logic       irq_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nib_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_src(tick_src), .irq_clear(irq_clear),
    .ovf_pulse(ovf_pulse), .irq_flag(irq_flag)
  );

  // vector: {wr, addr, wdata, tick, clr, expected rdata after edge, requirement number}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd0, 4'h1, 4'h0, 1'b0, 4'h1, 4'd2},
    {1'b1, 2'd1, 4'h5, 4'h0, 1'b0, 4'h0, 4'd5},
    {1'b1, 2'd2, 4'hA, 4'h0, 1'b0, 4'h0, 4'd5},
    {1'b0, 2'd1, 4'h0, 4'h1, 1'b0, 4'h1, 4'd3},
    {1'b0, 2'd1, 4'h0, 4'h2, 1'b0, 4'h1, 4'd3},
    {1'b0, 2'd1, 4'h0, 4'h1, 1'b0, 4'h2, 4'd6},
    {1'b1, 2'd0, 4'h5, 4'h1, 1'b0, 4'h5, 4'd2},
    {1'b0, 2'd1, 4'h0, 4'h1, 1'b0, 4'h3, 4'd3},
    {1'b0, 2'd1, 4'h0, 4'h4, 1'b0, 4'h4, 4'd3},
    {1'b1, 2'd0, 4'h4, 4'h4, 1'b0, 4'h4, 4'd4},
    {1'b0, 2'd1, 4'h0, 4'h4, 1'b0, 4'h5, 4'd4},
    {1'b1, 2'd3, 4'hF, 4'h0, 1'b0, 4'h0, 4'd2},
    {1'b0, 2'd0, 4'h0, 4'h0, 1'b0, 4'h4, 4'd2}
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [3:0] d,
                      input logic [3:0] tk, input logic clr);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick_src = tk; irq_clear = clr;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; tick_src = 4'h0; irq_clear = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 4'h0, 4'h1, 1'b0);
  endtask

  task automatic peek_cnt(output logic [7:0] v);
    reg_addr = 2'd1; #0.5; v[3:0] = reg_rdata;
    reg_addr = 2'd2; #0.5; v[7:4] = reg_rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #0.5;
      check("R1", "reset read", {4'h0, reg_rdata}, 8'h00);
    end
    check("R1", "reset ovf", {7'd0, ovf_pulse}, 8'h00);
    check("R1", "reset irq", {7'd0, irq_flag}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][19], VEC[v][18:17], VEC[v][16:13], VEC[v][12:9], VEC[v][8]);
      reg_addr = VEC[v][18:17]; #0.5;
      check($sformatf("R%0d", VEC[v][3:0]), $sformatf("vector %0d", v),
            {4'h0, reg_rdata}, {4'h0, VEC[v][7:4]});
    end

    // R7 R9 R10 overflow without reload
    step(1'b1, 2'd0, 4'h1, 4'h0, 1'b0);
    ticks(250);
    peek_cnt(c); check("R6", "count at top", c, 8'hFF);
    step(1'b0, 2'd0, 4'h0, 4'h1, 1'b0);
    peek_cnt(c); check("R7", "wrap to zero", c, 8'h00);
    check("R9", "ovf after wrap", {7'd0, ovf_pulse}, 8'h01);
    check("R10", "irq set", {7'd0, irq_flag}, 8'h01);
    step(1'b0, 2'd0, 4'h0, 4'h0, 1'b0);
    check("R9", "ovf one cycle", {7'd0, ovf_pulse}, 8'h00);
    check("R10", "irq held", {7'd0, irq_flag}, 8'h01);
    step(1'b0, 2'd0, 4'h0, 4'h0, 1'b1);
    check("R10", "irq cleared", {7'd0, irq_flag}, 8'h00);

    // R8 reload from preload 0xA5
    step(1'b1, 2'd0, 4'h9, 4'h0, 1'b0);
    ticks(255);
    step(1'b0, 2'd0, 4'h0, 4'h1, 1'b0);
    peek_cnt(c); check("R8", "reload value", c, 8'hA5);
    check("R10", "irq on reload wrap", {7'd0, irq_flag}, 8'h01);

    // R10 set wins over simultaneous clear
    ticks(90);
    step(1'b0, 2'd0, 4'h0, 4'h1, 1'b1);
    check("R10", "set beats clear", {7'd0, irq_flag}, 8'h01);
    peek_cnt(c); check("R8", "second reload", c, 8'hA5);
    step(1'b0, 2'd0, 4'h0, 4'h0, 1'b1);
    check("R10", "clear alone", {7'd0, irq_flag}, 8'h00);

    // R11 enabling does not load preload; R5 new preload used at next wrap
    step(1'b1, 2'd0, 4'h8, 4'h0, 1'b0);
    step(1'b1, 2'd1, 4'hC, 4'h1, 1'b0);
    step(1'b1, 2'd2, 4'h3, 4'h1, 1'b0);
    peek_cnt(c); check("R4", "held while off", c, 8'hA5);
    step(1'b1, 2'd0, 4'h9, 4'h0, 1'b0);
    peek_cnt(c); check("R11", "no load on enable", c, 8'hA5);
    step(1'b0, 2'd0, 4'h0, 4'h1, 1'b0);
    peek_cnt(c); check("R11", "resume from current", c, 8'hA6);
    ticks(89);
    step(1'b0, 2'd0, 4'h0, 4'h1, 1'b0);
    peek_cnt(c); check("R8", "reload new preload", c, 8'h3C);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule